// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a synchronous burst memory. A burst begins when either of two active-low start strobes is seen on a rising clock edge. One strobe comes from the processor and the other from the cache controller. On that edge the whole external address is captured. The two least significant bits then become the origin of a four-beat sequence, while the upper bits stay frozen for the whole burst.

After the start, the sequence moves forward one beat on each rising edge where the active-low advance input is low. When advance is high, the current address is held, which is how wait states are inserted. A static mode level chooses the order of the beats: interleaved, where the low bits are the origin XOR the beat index, or linear, where the origin is incremented modulo four. An advance taken on the last beat returns the address to the origin of the burst and ends the burst. A new strobe always restarts the sequence, even in the middle of a burst.

Top module: `burst_addr_seq`

## Requirements
- R1: While rst_ni is low, addr_o is 0 and burst_active_o is 0.
- R2: When either strobe (proc_strobe_ni or ctrl_strobe_ni, both active low) is low at a rising edge, addr_o equals the addr_i sampled at that edge and burst_active_o is 1 after the edge. Asserting both strobes together behaves the same as asserting one.
- R3: A strobe takes priority over advance. When a strobe and advance_ni are both low, the address is reloaded and no step is taken.
- R4: During a burst, with no strobe, each rising edge with advance_ni low moves addr_o to the next beat.
- R5: With no strobe and advance_ni high, addr_o and burst_active_o keep their values (suspend).
- R6: With mode_i = 1 (interleaved), beat n (n = 0..3) drives addr_o[1:0] = start[1:0] XOR n. For example, a start of 01 gives 01, 00, 11, 10.
- R7: With mode_i = 0 (linear), beat n drives addr_o[1:0] = (start[1:0] + n) mod 4. For example, a start of 10 gives 10, 11, 00, 01.
- R8: addr_o[15:2] changes only on a strobe and never carries from the low bits.
- R9: An advance on the fourth beat returns addr_o to the start address and clears burst_active_o. While no burst is active and no strobe is present, advance has no effect on addr_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| proc_strobe_ni | input | 1 | Processor burst start strobe, active low |
| ctrl_strobe_ni | input | 1 | Cache controller burst start strobe, active low |
| advance_ni | input | 1 | Step to next beat, active low |
| mode_i | input | 1 | 1 = interleaved order, 0 = linear order |
| addr_i | input | 16 | External start address |
| addr_o | output | 16 | Current word address |
| burst_active_o | output | 1 | A burst is in progress |

## Verification
All state sits in registers, and both outputs decode those registers directly. Every result is therefore due one rising edge after the stimulus that causes it, with no further delay. The bench drives inputs on the falling edge and samples 1 ns after the next rising edge, so each vector is compared in exactly the cycle its effect appears. Reset is checked while it is held, and again after an asynchronous reset taken in the middle of a burst.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam int unsigned BEAT_W = 2;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

  // low address bits for a given beat of the burst
  function automatic logic [BEAT_W-1:0] beat_addr(
    input logic [BEAT_W-1:0] origin,
    input logic [BEAT_W-1:0] beat,
    input order_e            order
  );
    if (order == ORDER_INTERLEAVE) return origin ^ beat;
    else                           return origin + beat;
  endfunction
endpackage

// File: rtl/bas_addr_reg.sv
module bas_addr_reg #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned BEAT_W = 2,
  localparam int unsigned UPPER_W = ADDR_W - BEAT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [UPPER_W-1:0] upper_o,
  output logic [BEAT_W-1:0]  origin_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upper_o  <= '0;
      origin_o <= '0;
    end else if (load_i) begin
      upper_o  <= addr_i[ADDR_W-1:BEAT_W];
      origin_o <= addr_i[BEAT_W-1:0];
    end
  end
endmodule

// File: rtl/bas_beat_ctr.sv
module bas_beat_ctr #(
  parameter int unsigned BEAT_W = 2,
  localparam logic [BEAT_W-1:0] LAST_BEAT = {BEAT_W{1'b1}}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o,
  output logic              active_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_o   <= '0;
      active_o <= 1'b0;
    end else if (load_i) begin
      beat_o   <= '0;
      active_o <= 1'b1;
    end else if (step_i && active_o) begin
      // past the final beat: back to origin, burst over
      beat_o   <= (beat_o == LAST_BEAT) ? '0 : beat_o + 1'b1;
      active_o <= (beat_o != LAST_BEAT);
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              proc_strobe_ni,
  input  logic              ctrl_strobe_ni,
  input  logic              advance_ni,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              burst_active_o
);
  import bas_pkg::*;
  localparam int unsigned UPPER_W = ADDR_W - BEAT_W;

  logic               load;
  logic               step;
  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  origin_q;
  logic [BEAT_W-1:0]  beat_q;
  order_e             order;

  assign load  = !proc_strobe_ni || !ctrl_strobe_ni;
  assign step  = !load && !advance_ni;
  assign order = order_e'(mode_i);

  bas_addr_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_addr_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .addr_i   (addr_i),
    .upper_o  (upper_q),
    .origin_o (origin_q)
  );

  bas_beat_ctr #(.BEAT_W(BEAT_W)) u_beat_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (load),
    .step_i   (step),
    .beat_o   (beat_q),
    .active_o (burst_active_o)
  );

  assign addr_o = {upper_q, beat_addr(origin_q, beat_q, order)};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int unsigned ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              proc_strobe_ni,
  input logic              ctrl_strobe_ni,
  input logic              advance_ni,
  input logic              mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              burst_active_o
);
  logic strobe;
  assign strobe = !proc_strobe_ni || !ctrl_strobe_ni;

  assert_start_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe |=> (addr_o == $past(addr_i)) && burst_active_o);

  assert_suspend_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe && advance_ni) |=> $stable(addr_o) && $stable(burst_active_o));

  assert_linear_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe && !advance_ni && burst_active_o && !mode_i)
      |=> addr_o[1:0] == $past(addr_o[1:0]) + 2'd1);

  assert_upper_fixed_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe |=> $stable(addr_o[ADDR_W-1:2]));

  assert_idle_no_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe && !burst_active_o) |=> $stable(addr_o) && !burst_active_o);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .proc_strobe_ni (proc_strobe_ni),
  .ctrl_strobe_ni (ctrl_strobe_ni),
  .advance_ni     (advance_ni),
  .mode_i         (mode_i),
  .addr_i         (addr_i),
  .addr_o         (addr_o),
  .burst_active_o (burst_active_o)
);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;
  typedef struct packed {
    logic [3:0]  req;
    logic        proc_n;
    logic        ctrl_n;
    logic        adv_n;
    logic        mode;
    logic [15:0] addr;
    logic [15:0] exp_addr;
    logic        exp_act;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{4'd2, 1'b0, 1'b1, 1'b1, 1'b1, 16'hABC5, 16'hABC5, 1'b1}, // R2 proc start
    '{4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0F0F, 16'hABC4, 1'b1}, // R6 01^1
    '{4'd5, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0F0F, 16'hABC4, 1'b1}, // R5 suspend
    '{4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0F0F, 16'hABC7, 1'b1}, // R6 01^2
    '{4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0F0F, 16'hABC6, 1'b1}, // R6 01^3
    '{4'd9, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0F0F, 16'hABC5, 1'b0}, // R9 wrap, end
    '{4'd9, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0F0F, 16'hABC5, 1'b0}, // R9 idle advance
    '{4'd2, 1'b1, 1'b0, 1'b1, 1'b0, 16'h1232, 16'h1232, 1'b1}, // R2 ctrl start
    '{4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0F0F, 16'h1233, 1'b1}, // R7 linear
    '{4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0F0F, 16'h1230, 1'b1}, // R8 no carry
    '{4'd3, 1'b0, 1'b1, 1'b0, 1'b0, 16'h4001, 16'h4001, 1'b1}, // R3 strobe wins
    '{4'd4, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0F0F, 16'h4002, 1'b1}, // R4 step
    '{4'd7, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0F0F, 16'h4003, 1'b1}, // R7
    '{4'd8, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0F0F, 16'h4000, 1'b1}, // R8
    '{4'd9, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0F0F, 16'h4001, 1'b0}, // R9
    '{4'd2, 1'b0, 1'b0, 1'b1, 1'b1, 16'hFFFF, 16'hFFFF, 1'b1}, // R2 both strobes
    '{4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0F0F, 16'hFFFE, 1'b1}  // R6 11^1
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        proc_strobe_ni = 1'b1;
  logic        ctrl_strobe_ni = 1'b1;
  logic        advance_ni = 1'b1;
  logic        mode_i = 1'b1;
  logic [15:0] addr_i = '0;
  logic [15:0] addr_o;
  logic        burst_active_o;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk_i = ~clk_i;

  burst_addr_seq u_burst_addr_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .proc_strobe_ni (proc_strobe_ni),
    .ctrl_strobe_ni (ctrl_strobe_ni),
    .advance_ni     (advance_ni),
    .mode_i         (mode_i),
    .addr_i         (addr_i),
    .addr_o         (addr_o),
    .burst_active_o (burst_active_o)
  );

  task automatic check(input int req, input logic [15:0] exp_a, input logic exp_v);
    n_checks++;
    if (addr_o !== exp_a || burst_active_o !== exp_v) begin
      n_fail++;
      $display("FAIL R%0d: addr=%h active=%b expected addr=%h active=%b",
               req, addr_o, burst_active_o, exp_a, exp_v);
    end
  endtask

  task automatic drive(input logic p, input logic c, input logic a, input logic m,
                       input logic [15:0] ad);
    @(negedge clk_i);
    proc_strobe_ni = p; ctrl_strobe_ni = c; advance_ni = a; mode_i = m; addr_i = ad;
    @(posedge clk_i); #1;
  endtask

  initial begin
    // R1: reset state while held, with a strobe present
    proc_strobe_ni = 1'b0; addr_i = 16'h5555;
    repeat (3) @(posedge clk_i);
    #1 check(1, 16'h0000, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1; proc_strobe_ni = 1'b1;

    foreach (VECS[i]) begin
      drive(VECS[i].proc_n, VECS[i].ctrl_n, VECS[i].adv_n, VECS[i].mode, VECS[i].addr);
      check(int'(VECS[i].req), VECS[i].exp_addr, VECS[i].exp_act);
    end

    // R6: interleaved from origin 10 -> 10,11,00,01
    drive(1'b0, 1'b1, 1'b1, 1'b1, 16'h8002);
    check(6, 16'h8002, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 16'h0000); check(6, 16'h8003, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 16'h0000); check(6, 16'h8000, 1'b1);
    drive(1'b1, 1'b1, 1'b0, 1'b1, 16'h0000); check(6, 16'h8001, 1'b1);

    // R1: asynchronous reset in mid burst
    @(negedge clk_i); rst_ni = 1'b0; #1;
    check(1, 16'h0000, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    // R9: advance after reset, no burst
    drive(1'b1, 1'b1, 1'b0, 1'b0, 16'h7777);
    check(9, 16'h0000, 1'b0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk_i);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule